// File: doc/BRIEF.md
# Smart Card Interface Control Register

This block is the control word of a smart card interface. Software reaches it through a plain 32-bit write/read port. It holds the transmit enable, the receive enable, the interrupt gate, the clock-stop request and the activation request. The datapath receives these as gated levels and as single-cycle command pulses. The sequencer, the UART and the FIFOs sit outside this block. Each of them connects through a dedicated signal.

Receive is held off for as long as the UART reports that a character is being sent. The warm-reset request is a write-1 strobe that is not stored. The activation request stays set until the sequencer reports that activation has finished. A software write in the same cycle overrides that completion.

Top module: `scr_ctrl`

## Requirements
- R1: During and after reset, the read data is 0x00000000 and every output is low until the first write.
- R2: The value written to bit 0 drives `tx_en_o` from the cycle after the write, and it reads back at bit 0.
- R3: The value written to bit 1 reads back at bit 1. `rx_en_o` equals that bit ANDed with the inverse of `tx_busy_i` in the same cycle.
- R4: The value written to bit 2 reads back at bit 2. `irq_o` equals the OR of `irq_src_i` ANDed with that bit.
- R5: The value written to bit 8 drives `clk_stop_o` from the cycle after the write, and it reads back at bit 8.
- R6: A write with bit 9 set makes `warm_rst_o` high for exactly the one cycle after the write. Bit 9 always reads 0.
- R7: A write with bit 10 set stores the activation request, which reads at bit 10. The same write gives a one-cycle `act_start_o` pulse in the cycle after it. A cycle with `act_done_i` high and no write clears the stored request. A write with bit 10 clear also clears it.
- R8: When a write and `act_done_i` fall in the same cycle, bit 10 takes the written value.
- R9: Bits 7:3 and 31:11 ignore writes and always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the control word |
| act_done_i | input | 1 | Activation finished, from the sequencer |
| tx_busy_i | input | 1 | Character transmission in progress, from the UART |
| irq_src_i | input | IRQ_W (4) | Raw interrupt sources |
| tx_en_o | output | 1 | Transmit enable |
| rx_en_o | output | 1 | Effective receive enable |
| irq_o | output | 1 | Gated interrupt request |
| clk_stop_o | output | 1 | Card clock stop request |
| act_start_o | output | 1 | One-cycle activation command |
| warm_rst_o | output | 1 | One-cycle warm reset command |

## Verification
The assertions expect `act_done_i`, `tx_busy_i` and the write strobe to be clean synchronous levels sampled at the rising edge. They assume no relation between `act_done_i` and any earlier activation request. The stimulus drives every input at the falling edge from seeded random values, so all inputs take arbitrary combinations. That includes a completion that arrives with no activation pending and one that lands on the same cycle as a write. Directed steps force the write-versus-completion collision and writes to all ones, so both the priority rule and the reserved bits are covered.

// File: rtl/scr_ctrl_pkg.sv
package scr_ctrl_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned TXEN_BIT  = 0;
  localparam int unsigned RXEN_BIT  = 1;
  localparam int unsigned GIE_BIT   = 2;
  localparam int unsigned CSTOP_BIT = 8;
  localparam int unsigned WRST_BIT  = 9;
  localparam int unsigned ACT_BIT   = 10;

  typedef struct packed {
    logic clk_stop;
    logic gie;
    logic rx_en;
    logic tx_en;
  } ctrl_t;

  function automatic logic [REG_W-1:0] pack_rdata(ctrl_t c, logic act);
    logic [REG_W-1:0] r;
    r            = '0;
    r[TXEN_BIT]  = c.tx_en;
    r[RXEN_BIT]  = c.rx_en;
    r[GIE_BIT]   = c.gie;
    r[CSTOP_BIT] = c.clk_stop;
    r[ACT_BIT]   = act;
    return r;
  endfunction
endpackage

// File: rtl/scr_ctrl_regs.sv
module scr_ctrl_regs
  import scr_ctrl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  ctrl_t wr_i,
  output ctrl_t ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_o <= '0;
    else if (we_i) ctrl_o <= wr_i;
  end
endmodule

// File: rtl/scr_ctrl_cmd.sv
module scr_ctrl_cmd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wr_act_i,
  input  logic wr_wrst_i,
  input  logic act_done_i,
  output logic act_q_o,
  output logic act_start_o,
  output logic warm_rst_o
);
  // software write beats hardware auto-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q_o     <= 1'b0;
      act_start_o <= 1'b0;
      warm_rst_o  <= 1'b0;
    end else begin
      act_start_o <= we_i & wr_act_i;
      warm_rst_o  <= we_i & wr_wrst_i;
      if (we_i)            act_q_o <= wr_act_i;
      else if (act_done_i) act_q_o <= 1'b0;
    end
  end
endmodule

// File: rtl/scr_ctrl_gate.sv
module scr_ctrl_gate
  import scr_ctrl_pkg::*;
#(
  parameter int unsigned IRQ_W = 4
) (
  input  ctrl_t            ctrl_i,
  input  logic             tx_busy_i,
  input  logic [IRQ_W-1:0] irq_src_i,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic             irq_o,
  output logic             clk_stop_o
);
  assign tx_en_o    = ctrl_i.tx_en;
  assign rx_en_o    = ctrl_i.rx_en & ~tx_busy_i;
  assign irq_o      = ctrl_i.gie & (|irq_src_i);
  assign clk_stop_o = ctrl_i.clk_stop;
endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_ctrl_pkg::*;
#(
  parameter int unsigned IRQ_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             act_done_i,
  input  logic             tx_busy_i,
  input  logic [IRQ_W-1:0] irq_src_i,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic             irq_o,
  output logic             clk_stop_o,
  output logic             act_start_o,
  output logic             warm_rst_o
);
  ctrl_t wr_ctrl, ctrl_q;
  logic  act_q;
  logic  unused_wdata;

  assign wr_ctrl.tx_en    = reg_wdata_i[TXEN_BIT];
  assign wr_ctrl.rx_en    = reg_wdata_i[RXEN_BIT];
  assign wr_ctrl.gie      = reg_wdata_i[GIE_BIT];
  assign wr_ctrl.clk_stop = reg_wdata_i[CSTOP_BIT];
  assign unused_wdata     = ^{reg_wdata_i[REG_W-1:ACT_BIT+1], reg_wdata_i[CSTOP_BIT-1:GIE_BIT+1]};

  scr_ctrl_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .wr_i   (wr_ctrl),
    .ctrl_o (ctrl_q)
  );

  scr_ctrl_cmd u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .wr_act_i    (reg_wdata_i[ACT_BIT]),
    .wr_wrst_i   (reg_wdata_i[WRST_BIT]),
    .act_done_i  (act_done_i),
    .act_q_o     (act_q),
    .act_start_o (act_start_o),
    .warm_rst_o  (warm_rst_o)
  );

  scr_ctrl_gate #(.IRQ_W(IRQ_W)) u_gate (
    .ctrl_i     (ctrl_q),
    .tx_busy_i  (tx_busy_i),
    .irq_src_i  (irq_src_i),
    .tx_en_o    (tx_en_o),
    .rx_en_o    (rx_en_o),
    .irq_o      (irq_o),
    .clk_stop_o (clk_stop_o)
  );

  assign reg_rdata_o = pack_rdata(ctrl_q, act_q);
endmodule

// File: rtl/scr_ctrl_chk.sv
module scr_ctrl_chk
  import scr_ctrl_pkg::*;
#(
  parameter int unsigned IRQ_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             act_done_i,
  input logic             tx_busy_i,
  input logic [IRQ_W-1:0] irq_src_i,
  input logic             tx_en_o,
  input logic             rx_en_o,
  input logic             irq_o,
  input logic             act_start_o,
  input logic             warm_rst_o
);
  p_tx_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> tx_en_o == $past(reg_wdata_i[TXEN_BIT]));
  p_rx_blocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |-> !rx_en_o);
  p_irq_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (reg_rdata_o[GIE_BIT] && (|irq_src_i)));
  p_warm_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_o |-> $past(reg_we_i && reg_wdata_i[WRST_BIT]));
  p_warm_reads0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[WRST_BIT]);
  p_act_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_start_o |-> reg_rdata_o[ACT_BIT]);
  p_act_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_done_i && !reg_we_i) |=> !reg_rdata_o[ACT_BIT]);
  p_act_prio_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_done_i && reg_we_i) |=> reg_rdata_o[ACT_BIT] == $past(reg_wdata_i[ACT_BIT]));
  p_rsvd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[CSTOP_BIT-1:GIE_BIT+1] == '0 && reg_rdata_o[REG_W-1:ACT_BIT+1] == '0);
endmodule

bind scr_ctrl scr_ctrl_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .act_done_i  (act_done_i),
  .tx_busy_i   (tx_busy_i),
  .irq_src_i   (irq_src_i),
  .tx_en_o     (tx_en_o),
  .rx_en_o     (rx_en_o),
  .irq_o       (irq_o),
  .act_start_o (act_start_o),
  .warm_rst_o  (warm_rst_o)
);

// File: tb/scr_ctrl_bench.sv
`timescale 1ns/1ps
module scr_ctrl_bench;
  localparam int IRQ_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             reg_we_i = 1'b0;
  logic [31:0]      reg_wdata_i = '0;
  logic [31:0]      reg_rdata_o;
  logic             act_done_i = 1'b0;
  logic             tx_busy_i = 1'b0;
  logic [IRQ_W-1:0] irq_src_i = '0;
  logic tx_en_o, rx_en_o, irq_o, clk_stop_o, act_start_o, warm_rst_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state
  logic m_tx = 0, m_rx = 0, m_gie = 0, m_cs = 0, m_act = 0, m_ast = 0, m_wrst = 0;

  always #2.5 clk_i = ~clk_i;

  scr_ctrl #(.IRQ_W(IRQ_W)) u_scr_ctrl (.*);

  function automatic logic [31:0] exp_rdata();
    logic [31:0] r = '0;
    r[0] = m_tx; r[1] = m_rx; r[2] = m_gie; r[8] = m_cs; r[10] = m_act;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2/R3/R4/R5/R7/R9 rdata", reg_rdata_o, exp_rdata());
    chk("R2 tx_en", 32'(tx_en_o), 32'(m_tx));
    chk("R3 rx_en", 32'(rx_en_o), 32'(m_rx & ~tx_busy_i));
    chk("R4 irq", 32'(irq_o), 32'(m_gie & (|irq_src_i)));
    chk("R5 clk_stop", 32'(clk_stop_o), 32'(m_cs));
    chk("R6 warm_rst", 32'(warm_rst_o), 32'(m_wrst));
    chk("R7 act_start", 32'(act_start_o), 32'(m_ast));
  endtask

  task automatic step(logic we, logic [31:0] wd, logic dn, logic busy, logic [IRQ_W-1:0] irq);
    @(negedge clk_i);
    reg_we_i = we; reg_wdata_i = wd; act_done_i = dn; tx_busy_i = busy; irq_src_i = irq;
    #1 check_all();
    @(posedge clk_i);
    m_wrst = we & wd[9];
    m_ast  = we & wd[10];
    if (we) begin
      m_tx = wd[0]; m_rx = wd[1]; m_gie = wd[2]; m_cs = wd[8]; m_act = wd[10];
    end else if (dn) m_act = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    reg_we_i = 1'b1; reg_wdata_i = '1; act_done_i = 1'b0; tx_busy_i = 1'b0; irq_src_i = '1;
    #12;
    // R1: reset state held despite write attempts
    chk("R1 rdata in reset", reg_rdata_o, 32'h0);
    chk("R1 outputs in reset", 32'({tx_en_o, rx_en_o, irq_o, clk_stop_o, act_start_o, warm_rst_o}), 32'h0);
    @(negedge clk_i);
    reg_we_i = 1'b0; rst_ni = 1'b1;
    step(0, '0, 0, 0, '1);               // R1 after reset
    // R9: all ones write, reserved bits read 0, warm reads 0 (R6)
    step(1, 32'hFFFF_FFFF, 0, 0, 4'h1);
    step(0, '0, 0, 0, 4'h1);             // R6 pulse visible, R7 act pulse
    step(0, '0, 0, 1, 4'h0);             // R6 pulse gone, R3 busy gating
    step(0, '0, 1, 0, 4'h2);             // R7 auto-clear
    step(0, '0, 0, 0, 4'h0);
    step(1, 32'h0000_0400, 0, 0, 4'h0);  // R7 set
    step(1, 32'h0000_0400, 1, 0, 4'h0);  // R8 write 1 beats done
    step(1, 32'h0000_0000, 1, 0, 4'h0);  // R8 write 0 with done
    step(1, 32'h0000_0400, 0, 0, 4'h0);
    step(1, 32'h0000_0000, 0, 0, 4'h0);  // R7 write 0 clears
    step(1, 32'h0000_0006, 0, 1, 4'h8);  // R3/R4
    step(0, '0, 0, 1, 4'h8);
    step(0, '0, 0, 0, 4'h0);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] wd;
      wd = $urandom;
      step(($urandom % 3) == 0, wd, ($urandom % 4) == 0, $urandom % 2, IRQ_W'($urandom));
    end
    step(0, '0, 0, 0, '0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule